// File: doc/BRIEF.md
# Scaler Parameter Register File

This block holds the programming state of an image scaling engine and sits on a simple 32-bit register bus made of a byte address, a write strobe and write data. It keeps the control bits, the input and output frame sizes and the four phase words that the filter datapath reads as steady outputs. It also loads two polyphase coefficient tables, one for vertical and one for horizontal filtering, each 96 entries of 14 bits.

The tables are loaded through two registers. A single address write sets the start index and picks the target table or tables. After that, each data write stores one coefficient and moves the index on by one, so 96 data writes fill a table. When both select bits are set, one burst loads the same values into both tables. The filter datapath reads each table through its own read port, which has one cycle of latency.

Top module: `scl_regfile`

## Requirements
- R1: The control register is at offset 0x00. Bit 0 is scaling enable, bit 1 is alpha enable and bit 4 is RGB output interface enable. A write drives `scale_en_o`, `alpha_en_o` and `rgb_if_en_o` from the next clock edge. Readback returns only those three bits, with all other bits zero.
- R2: The input size register is at 0x14 and the output size register is at 0x18. Bits 28:16 hold the vertical size and bits 12:0 hold the horizontal size, both 13 bits. A write discards every other bit. Readback and the size outputs show the masked fields.
- R3: The phase registers are at 0x24 (horizontal initial), 0x28 (horizontal delta), 0x2C (vertical initial) and 0x30 (vertical delta). Each holds all 32 bits and drives its own output.
- R4: The coefficient address register is at 0x34. Bits 6:0 hold the start index, bit 8 selects the vertical table and bit 9 selects the horizontal table. A start index above 95 is stored as 95. Readback returns the current index in bits 6:0 and the two select bits in bits 8 and 9.
- R5: A write to the coefficient data register at 0x38 stores bits 13:0 at the current index of every selected table. With both select bits set, both tables receive the same value.
- R6: Each data write with at least one table selected advances the index by one. At index 95 the index stays put, so further writes overwrite entry 95.
- R7: A data write with neither select bit set changes neither table, and the index does not move.
- R8: Reset clears every register and every output to zero. Reads of the data register and of unmapped offsets return zero.
- R9: `rdata_o` shows the register addressed in a cycle after the following clock edge. Each table read port returns the entry at its address after the following clock edge.
- R10: Writes to unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Register byte offset |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| scale_en_o | output | 1 | Scaling enable |
| alpha_en_o | output | 1 | Alpha enable |
| rgb_if_en_o | output | 1 | RGB output interface enable |
| in_h_size_o | output | 13 | Input horizontal size |
| in_v_size_o | output | 13 | Input vertical size |
| out_h_size_o | output | 13 | Output horizontal size |
| out_v_size_o | output | 13 | Output vertical size |
| h_init_ph_o | output | 32 | Horizontal initial phase |
| h_delta_ph_o | output | 32 | Horizontal phase step |
| v_init_ph_o | output | 32 | Vertical initial phase |
| v_delta_ph_o | output | 32 | Vertical phase step |
| hcoef_raddr_i | input | 7 | Horizontal table read index |
| hcoef_rdata_o | output | 14 | Horizontal table read data |
| vcoef_raddr_i | input | 7 | Vertical table read index |
| vcoef_rdata_o | output | 14 | Vertical table read data |

## Verification
Each write takes effect at the clock edge on which it is presented. A register read or table read is presented in one cycle and its value appears one edge later. The bench changes inputs on the falling edge and samples on the next falling edge, so every value it checks has passed exactly one rising edge. One check samples just before that edge to confirm that `rdata_o` still holds the previous value. The index checks read the address register back after each burst: after a run into the end of the table, after an ignored unselected write, and after a clamped start index.

// File: rtl/scl_pkg.sv
package scl_pkg;
  localparam int unsigned SIZE_W = 13;
  localparam int unsigned COEF_W = 14;
  localparam int unsigned COEF_N = 96;

  localparam int unsigned OFF_CTRL     = 'h00;
  localparam int unsigned OFF_IN_SIZE  = 'h14;
  localparam int unsigned OFF_OUT_SIZE = 'h18;
  localparam int unsigned OFF_H_INIT   = 'h24;
  localparam int unsigned OFF_H_DELTA  = 'h28;
  localparam int unsigned OFF_V_INIT   = 'h2C;
  localparam int unsigned OFF_V_DELTA  = 'h30;
  localparam int unsigned OFF_CADDR    = 'h34;
  localparam int unsigned OFF_CDATA    = 'h38;

  localparam int unsigned CTRL_SCALE_BIT = 0;
  localparam int unsigned CTRL_ALPHA_BIT = 1;
  localparam int unsigned CTRL_RGB_BIT   = 4;
  localparam int unsigned SEL_V_BIT      = 8;
  localparam int unsigned SEL_H_BIT      = 9;
  localparam int unsigned V_LSB          = 16;

  localparam int unsigned TBL_V = 0;
  localparam int unsigned TBL_H = 1;

  typedef enum logic [3:0] {
    REG_NONE, REG_CTRL, REG_IN, REG_OUT,
    REG_HI, REG_HD, REG_VI, REG_VD, REG_CADDR, REG_CDATA
  } reg_sel_e;
endpackage

// File: rtl/scl_addr_dec.sv
module scl_addr_dec
  import scl_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o
);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_IN    = ADDR_W'(OFF_IN_SIZE);
  localparam logic [ADDR_W-1:0] A_OUT   = ADDR_W'(OFF_OUT_SIZE);
  localparam logic [ADDR_W-1:0] A_HI    = ADDR_W'(OFF_H_INIT);
  localparam logic [ADDR_W-1:0] A_HD    = ADDR_W'(OFF_H_DELTA);
  localparam logic [ADDR_W-1:0] A_VI    = ADDR_W'(OFF_V_INIT);
  localparam logic [ADDR_W-1:0] A_VD    = ADDR_W'(OFF_V_DELTA);
  localparam logic [ADDR_W-1:0] A_CADDR = ADDR_W'(OFF_CADDR);
  localparam logic [ADDR_W-1:0] A_CDATA = ADDR_W'(OFF_CDATA);

  always_comb begin
    case (addr_i)
      A_CTRL:  sel_o = REG_CTRL;
      A_IN:    sel_o = REG_IN;
      A_OUT:   sel_o = REG_OUT;
      A_HI:    sel_o = REG_HI;
      A_HD:    sel_o = REG_HD;
      A_VI:    sel_o = REG_VI;
      A_VD:    sel_o = REG_VD;
      A_CADDR: sel_o = REG_CADDR;
      A_CDATA: sel_o = REG_CDATA;
      default: sel_o = REG_NONE;
    endcase
  end
endmodule

// File: rtl/scl_reg_bank.sv
module scl_reg_bank
  import scl_pkg::*;
#(
  parameter int unsigned SIZE_W = scl_pkg::SIZE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  reg_sel_e          sel_i,
  input  logic [31:0]       wdata_i,
  output logic              scale_en_o,
  output logic              alpha_en_o,
  output logic              rgb_en_o,
  output logic [SIZE_W-1:0] in_h_o,
  output logic [SIZE_W-1:0] in_v_o,
  output logic [SIZE_W-1:0] out_h_o,
  output logic [SIZE_W-1:0] out_v_o,
  output logic [3:0][31:0]  ph_o
);
  logic unused_ok;
  assign unused_ok = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scale_en_o <= 1'b0;
      alpha_en_o <= 1'b0;
      rgb_en_o   <= 1'b0;
      in_h_o     <= '0;
      in_v_o     <= '0;
      out_h_o    <= '0;
      out_v_o    <= '0;
    end else if (wr_i) begin
      case (sel_i)
        REG_CTRL: begin
          scale_en_o <= wdata_i[CTRL_SCALE_BIT];
          alpha_en_o <= wdata_i[CTRL_ALPHA_BIT];
          rgb_en_o   <= wdata_i[CTRL_RGB_BIT];
        end
        REG_IN: begin
          in_h_o <= wdata_i[0 +: SIZE_W];
          in_v_o <= wdata_i[V_LSB +: SIZE_W];
        end
        REG_OUT: begin
          out_h_o <= wdata_i[0 +: SIZE_W];
          out_v_o <= wdata_i[V_LSB +: SIZE_W];
        end
        default: ;
      endcase
    end
  end

  // phase words: 0 h init, 1 h delta, 2 v init, 3 v delta
  localparam reg_sel_e PH_SEL [4] = '{REG_HI, REG_HD, REG_VI, REG_VD};

  for (genvar k = 0; k < 4; k++) begin : g_ph
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         ph_o[k] <= '0;
      else if (wr_i && sel_i == PH_SEL[k]) ph_o[k] <= wdata_i;
    end
  end
endmodule

// File: rtl/scl_coef_port.sv
module scl_coef_port
  import scl_pkg::*;
#(
  parameter int unsigned COEF_W = scl_pkg::COEF_W,
  parameter int unsigned COEF_N = scl_pkg::COEF_N,
  parameter int unsigned IDX_W  = $clog2(COEF_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  reg_sel_e          sel_i,
  input  logic [31:0]       wdata_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic              sel_h_o,
  output logic              sel_v_o,
  output logic [1:0]        we_o,
  output logic [IDX_W-1:0]  waddr_o,
  output logic [COEF_W-1:0] wdata_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(COEF_N - 1);

  logic unused_ok;
  assign unused_ok = ^wdata_i;

  logic             data_wr;
  logic             any_sel;
  logic [IDX_W-1:0] start_idx;

  assign data_wr   = wr_i && (sel_i == REG_CDATA);
  assign any_sel   = sel_h_o || sel_v_o;
  assign start_idx = wdata_i[IDX_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_o   <= '0;
      sel_h_o <= 1'b0;
      sel_v_o <= 1'b0;
    end else if (wr_i && sel_i == REG_CADDR) begin
      idx_o   <= (start_idx > LAST) ? LAST : start_idx;
      sel_v_o <= wdata_i[SEL_V_BIT];
      sel_h_o <= wdata_i[SEL_H_BIT];
    end else if (data_wr && any_sel && idx_o != LAST) begin
      idx_o <= idx_o + 1'b1;
    end
  end

  assign we_o[TBL_V] = data_wr && sel_v_o;
  assign we_o[TBL_H] = data_wr && sel_h_o;
  assign waddr_o     = idx_o;
  assign wdata_o     = wdata_i[COEF_W-1:0];
endmodule

// File: rtl/scl_coef_ram.sv
module scl_coef_ram #(
  parameter int unsigned COEF_W = 14,
  parameter int unsigned COEF_N = 96,
  parameter int unsigned IDX_W  = $clog2(COEF_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  waddr_i,
  input  logic [COEF_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  raddr_i,
  output logic [COEF_W-1:0] rdata_o
);
  localparam logic [IDX_W-1:0] DEPTH = IDX_W'(COEF_N);

  logic [COEF_W-1:0] mem [COEF_N];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                rdata_o <= '0;
    else if (raddr_i < DEPTH)   rdata_o <= mem[raddr_i];
    else                        rdata_o <= '0;
  end
endmodule

// File: rtl/scl_regfile.sv
module scl_regfile
  import scl_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned SIZE_W = scl_pkg::SIZE_W,
  parameter int unsigned COEF_W = scl_pkg::COEF_W,
  parameter int unsigned COEF_N = scl_pkg::COEF_N,
  parameter int unsigned IDX_W  = $clog2(COEF_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              scale_en_o,
  output logic              alpha_en_o,
  output logic              rgb_if_en_o,
  output logic [SIZE_W-1:0] in_h_size_o,
  output logic [SIZE_W-1:0] in_v_size_o,
  output logic [SIZE_W-1:0] out_h_size_o,
  output logic [SIZE_W-1:0] out_v_size_o,
  output logic [31:0]       h_init_ph_o,
  output logic [31:0]       h_delta_ph_o,
  output logic [31:0]       v_init_ph_o,
  output logic [31:0]       v_delta_ph_o,
  input  logic [IDX_W-1:0]  hcoef_raddr_i,
  output logic [COEF_W-1:0] hcoef_rdata_o,
  input  logic [IDX_W-1:0]  vcoef_raddr_i,
  output logic [COEF_W-1:0] vcoef_rdata_o
);
  reg_sel_e          reg_sel;
  logic [3:0][31:0]  ph;
  logic [IDX_W-1:0]  coef_idx;
  logic              sel_h;
  logic              sel_v;
  logic [1:0]        tbl_we;
  logic [IDX_W-1:0]  tbl_waddr;
  logic [COEF_W-1:0] tbl_wdata;
  logic [1:0][IDX_W-1:0]  tbl_raddr;
  logic [1:0][COEF_W-1:0] tbl_rdata;
  logic [31:0]       rdata_d;

  scl_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (addr_i),
    .sel_o  (reg_sel)
  );

  scl_reg_bank #(.SIZE_W(SIZE_W)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_en_i),
    .sel_i      (reg_sel),
    .wdata_i    (wdata_i),
    .scale_en_o (scale_en_o),
    .alpha_en_o (alpha_en_o),
    .rgb_en_o   (rgb_if_en_o),
    .in_h_o     (in_h_size_o),
    .in_v_o     (in_v_size_o),
    .out_h_o    (out_h_size_o),
    .out_v_o    (out_v_size_o),
    .ph_o       (ph)
  );

  assign h_init_ph_o  = ph[0];
  assign h_delta_ph_o = ph[1];
  assign v_init_ph_o  = ph[2];
  assign v_delta_ph_o = ph[3];

  scl_coef_port #(.COEF_W(COEF_W), .COEF_N(COEF_N), .IDX_W(IDX_W)) u_port (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_en_i),
    .sel_i   (reg_sel),
    .wdata_i (wdata_i),
    .idx_o   (coef_idx),
    .sel_h_o (sel_h),
    .sel_v_o (sel_v),
    .we_o    (tbl_we),
    .waddr_o (tbl_waddr),
    .wdata_o (tbl_wdata)
  );

  assign tbl_raddr[TBL_V] = vcoef_raddr_i;
  assign tbl_raddr[TBL_H] = hcoef_raddr_i;

  for (genvar t = 0; t < 2; t++) begin : g_tbl
    scl_coef_ram #(.COEF_W(COEF_W), .COEF_N(COEF_N), .IDX_W(IDX_W)) u_ram (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (tbl_we[t]),
      .waddr_i (tbl_waddr),
      .wdata_i (tbl_wdata),
      .raddr_i (tbl_raddr[t]),
      .rdata_o (tbl_rdata[t])
    );
  end

  assign vcoef_rdata_o = tbl_rdata[TBL_V];
  assign hcoef_rdata_o = tbl_rdata[TBL_H];

  always_comb begin
    rdata_d = '0;
    case (reg_sel)
      REG_CTRL: begin
        rdata_d[CTRL_SCALE_BIT] = scale_en_o;
        rdata_d[CTRL_ALPHA_BIT] = alpha_en_o;
        rdata_d[CTRL_RGB_BIT]   = rgb_if_en_o;
      end
      REG_IN: begin
        rdata_d[0 +: SIZE_W]     = in_h_size_o;
        rdata_d[V_LSB +: SIZE_W] = in_v_size_o;
      end
      REG_OUT: begin
        rdata_d[0 +: SIZE_W]     = out_h_size_o;
        rdata_d[V_LSB +: SIZE_W] = out_v_size_o;
      end
      REG_HI: rdata_d = ph[0];
      REG_HD: rdata_d = ph[1];
      REG_VI: rdata_d = ph[2];
      REG_VD: rdata_d = ph[3];
      REG_CADDR: begin
        rdata_d[IDX_W-1:0] = coef_idx;
        rdata_d[SEL_V_BIT] = sel_v;
        rdata_d[SEL_H_BIT] = sel_h;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= rdata_d;
  end
endmodule

// File: rtl/scl_regfile_chk.sv
module scl_regfile_chk
  import scl_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned SIZE_W = scl_pkg::SIZE_W,
  parameter int unsigned COEF_N = scl_pkg::COEF_N,
  parameter int unsigned IDX_W  = $clog2(COEF_N)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_en_i,
  input logic [31:0]       wdata_i,
  input logic [31:0]       rdata_o,
  input logic              scale_en_o,
  input logic [IDX_W-1:0]  coef_idx,
  input logic              sel_h,
  input logic              sel_v
);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_IN    = ADDR_W'(OFF_IN_SIZE);
  localparam logic [ADDR_W-1:0] A_OUT   = ADDR_W'(OFF_OUT_SIZE);
  localparam logic [ADDR_W-1:0] A_CDATA = ADDR_W'(OFF_CDATA);
  localparam logic [IDX_W-1:0]  LAST    = IDX_W'(COEF_N - 1);
  localparam logic [31:0] SIZE_HOLES =
    ~((32'((1 << SIZE_W) - 1) << V_LSB) | 32'((1 << SIZE_W) - 1));

  logic unused_ok;
  assign unused_ok = ^wdata_i;

  logic data_wr;
  assign data_wr = wr_en_i && addr_i == A_CDATA;

  a_r1_ctrl_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_CTRL) |=> scale_en_o == $past(wdata_i[CTRL_SCALE_BIT]));

  a_r2_size_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_IN || addr_i == A_OUT) |=> (rdata_o & SIZE_HOLES) == 32'h0);

  a_r6_idx_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coef_idx <= LAST);

  a_r6_idx_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr && (sel_h || sel_v) && coef_idx < LAST)
      |=> coef_idx == IDX_W'($past(coef_idx) + 1'b1));

  a_r7_nosel_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr && !sel_h && !sel_v) |=> $stable(coef_idx));

  a_r8_data_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_CDATA) |=> rdata_o == 32'h0);
endmodule

bind scl_regfile scl_regfile_chk #(
  .ADDR_W (ADDR_W),
  .SIZE_W (SIZE_W),
  .COEF_N (COEF_N),
  .IDX_W  (IDX_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_i     (addr_i),
  .wr_en_i    (wr_en_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .scale_en_o (scale_en_o),
  .coef_idx   (coef_idx),
  .sel_h      (sel_h),
  .sel_v      (sel_v)
);

// File: tb/scl_regfile_tb.sv
module scl_regfile_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr_i = '0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        scale_en_o, alpha_en_o, rgb_if_en_o;
  logic [12:0] in_h_size_o, in_v_size_o, out_h_size_o, out_v_size_o;
  logic [31:0] h_init_ph_o, h_delta_ph_o, v_init_ph_o, v_delta_ph_o;
  logic [6:0]  hcoef_raddr_i = '0;
  logic [6:0]  vcoef_raddr_i = '0;
  logic [13:0] hcoef_rdata_o, vcoef_rdata_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [13:0] exp_h [96];
  logic [13:0] exp_v [96];

  always #4 clk_i = ~clk_i;

  scl_regfile dut_i (
    .clk_i, .rst_ni, .addr_i, .wr_en_i, .wdata_i, .rdata_o,
    .scale_en_o, .alpha_en_o, .rgb_if_en_o,
    .in_h_size_o, .in_v_size_o, .out_h_size_o, .out_v_size_o,
    .h_init_ph_o, .h_delta_ph_o, .v_init_ph_o, .v_delta_ph_o,
    .hcoef_raddr_i, .hcoef_rdata_o, .vcoef_raddr_i, .vcoef_rdata_o
  );

  // {addr, write data, expected readback}
  localparam logic [71:0] VEC [10] = '{
    {8'h00, 32'hFFFF_FFFF, 32'h0000_0013},
    {8'h14, 32'hFFFF_FFFF, 32'h1FFF_1FFF},
    {8'h18, 32'h1234_5678, 32'h1234_1678},
    {8'h24, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
    {8'h28, 32'h0001_2345, 32'h0001_2345},
    {8'h2C, 32'h0000_0005, 32'h0000_0005},
    {8'h30, 32'hCAFE_F00D, 32'hCAFE_F00D},
    {8'h34, 32'hFFFF_FF85, 32'h0000_0305},
    {8'h38, 32'h0000_0000, 32'h0000_0000},
    {8'h40, 32'hFFFF_FFFF, 32'h0000_0000}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic wr(logic [7:0] a, logic [31:0] d);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    addr_i = a; wr_en_i = 1'b0;
    @(negedge clk_i);
    d = rdata_o;
  endtask

  task automatic rd_tbl(int i, output logic [13:0] h, output logic [13:0] v);
    hcoef_raddr_i = 7'(i); vcoef_raddr_i = 7'(i);
    @(negedge clk_i);
    h = hcoef_rdata_o; v = vcoef_rdata_o;
  endtask

  task automatic check_tables(string req);
    logic [13:0] h, v;
    int bad = 0;
    for (int i = 0; i < 96; i++) begin
      rd_tbl(i, h, v);
      if (h !== exp_h[i] || v !== exp_v[i]) begin
        bad++;
        $display("FAIL %s entry %0d actual=%h/%h expected=%h/%h",
                 req, i, h, v, exp_h[i], exp_v[i]);
      end
    end
    checks++;
    if (bad != 0) errors++;
  endtask

  initial begin
    logic [31:0] r;
    logic [13:0] th, tv;
    repeat (3) @(negedge clk_i);
    check("R8 reset ctrl outputs", {29'h0, scale_en_o, alpha_en_o, rgb_if_en_o}, 32'h0);
    check("R8 reset sizes", {in_h_size_o, in_v_size_o, out_h_size_o[5:0]}, 32'h0);
    check("R8 reset phase", h_init_ph_o | v_delta_ph_o, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    rd(8'h00, r); check("R8 reset ctrl readback", r, 32'h0);
    rd(8'h34, r); check("R8 reset coef addr readback", r, 32'h0);

    // table walk: write each register, then read it back
    for (int k = 0; k < 10; k++) begin
      wr(VEC[k][71:64], VEC[k][63:32]);
      rd(VEC[k][71:64], r);
      check($sformatf("R1/R2/R3/R4/R8/R10 vector %0d", k), r, VEC[k][31:0]);
    end

    rd(8'h00, r); check("R10 unmapped write left ctrl", r, 32'h13);
    rd(8'h24, r); check("R10 unmapped write left phase", r, 32'hDEAD_BEEF);
    check("R1 enables set", {29'h0, scale_en_o, alpha_en_o, rgb_if_en_o}, 32'h7);
    check("R2 in size outputs", {3'h0, in_v_size_o, 3'h0, in_h_size_o}, 32'h1FFF_1FFF);
    check("R2 out size outputs", {3'h0, out_v_size_o, 3'h0, out_h_size_o}, 32'h1234_1678);
    check("R3 h delta output", h_delta_ph_o, 32'h0001_2345);
    check("R3 v init output", v_init_ph_o, 32'h5);
    check("R3 v delta output", v_delta_ph_o, 32'hCAFE_F00D);
    wr(8'h00, 32'h0000_0002);
    check("R1 alpha only", {29'h0, scale_en_o, alpha_en_o, rgb_if_en_o}, 32'h2);

    // R9: before the edge rdata_o still holds the previous read
    rd(8'h14, r);
    addr_i = 8'h00;
    #1 check("R9 readback not early", rdata_o, 32'h1FFF_1FFF);
    @(negedge clk_i);
    check("R9 readback after one edge", rdata_o, 32'h2);

    // R5: load both tables in one burst
    wr(8'h34, 32'h0000_0300);
    for (int i = 0; i < 96; i++) begin
      wr(8'h38, 32'hFFFF_C000 | 32'(i * 37 + 5));
      exp_h[i] = 14'(i * 37 + 5);
      exp_v[i] = 14'(i * 37 + 5);
    end
    rd(8'h34, r); check("R6 index held at 95 after full load", r, 32'h0000_035F);
    check_tables("R5 R9 dual load");

    // R5: horizontal only at 10..12, vertical only at 20
    wr(8'h34, 32'h0000_020A);
    for (int i = 10; i < 13; i++) begin
      wr(8'h38, 32'(14'h2A00 + 14'(i)));
      exp_h[i] = 14'h2A00 + 14'(i);
    end
    rd(8'h34, r); check("R6 index advanced by 3", r, 32'h0000_020D);
    wr(8'h34, 32'h0000_0114);
    wr(8'h38, 32'h0000_1555);
    exp_v[20] = 14'h1555;
    rd(8'h34, r); check("R4 vertical select readback", r, 32'h0000_0115);

    // R7: no table selected
    wr(8'h34, 32'h0000_001E);
    wr(8'h38, 32'h0000_3FFF);
    rd(8'h34, r); check("R7 index unmoved", r, 32'h0000_001E);
    rd_tbl(30, th, tv);
    check("R7 tables unchanged", {18'h0, th}, {18'h0, exp_h[30]});
    check("R7 vertical unchanged", {18'h0, tv}, {18'h0, exp_v[30]});

    // R6: run into the last entry
    wr(8'h34, 32'h0000_035E);
    wr(8'h38, 32'h0000_0111);
    wr(8'h38, 32'h0000_0222);
    wr(8'h38, 32'h0000_0333);
    exp_h[94] = 14'h111; exp_v[94] = 14'h111;
    exp_h[95] = 14'h333; exp_v[95] = 14'h333;
    rd(8'h34, r); check("R6 saturated index", r, 32'h0000_035F);
    check_tables("R5 R6 R7 table contents");

    // R4: start index above 95 clamps
    wr(8'h34, 32'h0000_017F);
    rd(8'h34, r); check("R4 start index clamp", r, 32'h0000_015F);

    // R8: reset mid-run
    rst_ni = 1'b0;
    @(negedge clk_i);
    check("R8 async reset ctrl", {29'h0, scale_en_o, alpha_en_o, rgb_if_en_o}, 32'h0);
    check("R8 async reset rdata", rdata_o, 32'h0);
    check("R8 async reset phase", h_delta_ph_o, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    rd(8'h18, r); check("R8 out size cleared", r, 32'h0);
    rd(8'h34, r); check("R8 coef addr cleared", r, 32'h0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule